// File: doc/BRIEF.md
# Codec Power-State and Master-Clock-Loss Controller

This block manages the power state of the digital side of a telephone audio codec. It watches decoded control-instruction bytes from the serial control port. Each byte arrives with a one-cycle valid strobe, plus a flag that marks a stand-alone single-byte instruction. Any qualifying byte powers the codec up or down according to its power bit. The block also gates the transmit-data output driver and the auxiliary line driver. It monitors the master clock with a free-running reference clock and forces a reset power-down if that clock stalls.

All logic runs on the reference clock `clk_i`. The master clock is asynchronous and is synchronized before edge detection. The frame-sync pulse and the B-slot enable are taken as synchronous to `clk_i`. After each power-up, the transmit driver stays off until two frame-sync rising edges have been seen. From then on it follows the B-slot enable.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After reset `pwr_up_o`, `tx_oe_o`, `aux_oe_o` and `clk_loss_o` are all 0. The block is in the powered-down state.
- R2: On a qualifying byte with `instr_valid_i` high, bit 2 of `instr_i` selects the power state. 0 means power up and 1 means power down. `pwr_up_o` takes the new value one `clk_i` cycle later.
- R3: A byte with `single_byte_i` high and bit 1 of `instr_i` equal to 1 is not a power command and leaves the state unchanged. The same bit pattern with `single_byte_i` low is a power command.
- R4: After a power-up, `tx_oe_o` stays 0 until the second rising edge of `fs_i` seen while powered up. This holds even with `bslot_i` high.
- R5: While powered up and past the two-frame wait, `tx_oe_o` equals `bslot_i` in the same cycle.
- R6: `aux_oe_o` equals `pwr_up_o` at all times.
- R7: When no edge of `mclk_i` has been seen for 64 consecutive `clk_i` cycles, the block enters the reset power-down state. In that state `clk_loss_o` = 1, `pwr_up_o` = 0, `tx_oe_o` = 0 and `aux_oe_o` = 0.
- R8: In the reset power-down state, a power-up command is ignored while the master clock is still absent. Once edges return, a power-up command powers up the block and clears `clk_loss_o`.
- R9: The frame-sync count is cleared on every power-down. Each new power-up waits again for two `fs_i` edges.
- R10: Bytes presented with `instr_valid_i` low have no effect.
- R11: `fs_i` edges seen while powered down do not count toward the two-frame wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mclk_i | input | 1 | Master clock, asynchronous, monitored for activity |
| fs_i | input | 1 | Frame-sync pulse |
| bslot_i | input | 1 | High during a selected B-channel time slot |
| instr_i | input | 8 | Decoded control-instruction byte |
| instr_valid_i | input | 1 | One-cycle strobe qualifying `instr_i` |
| single_byte_i | input | 1 | Byte is a stand-alone single-byte instruction |
| pwr_up_o | output | 1 | Codec powered up |
| tx_oe_o | output | 1 | Output enable for the transmit-data pin |
| aux_oe_o | output | 1 | Output enable for the auxiliary line pin |
| clk_loss_o | output | 1 | Set after a master-clock-loss reset |

## Verification
The bench holds `bslot_i` high across both frame-sync edges after power-up. A gate that opens on the first edge, or that ignores the slot enable, drives the transmit pin early. It repeats power-down and power-up, and also pulses `fs_i` while powered down. A counter that is not cleared, or that counts while powered down, skips the wait on the next power-up. It stops the master clock and checks that the loss is declared near the 64-cycle limit. It then sends a power-up command while the clock is still absent. A design that acts on it would leave the loss state with no clock. It also sends single-byte instructions with bit 1 set. A decoder that skips this guard changes the power state on a byte that is not a power command.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  typedef enum logic [1:0] {
    ST_DOWN = 2'd0,
    ST_UP   = 2'd1,
    ST_LOSS = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/instr_decode.sv
module instr_decode #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned P_BIT     = 2,
  parameter int unsigned GUARD_BIT = 1
) (
  input  logic [BYTE_W-1:0] instr_i,
  input  logic              valid_i,
  input  logic              single_i,
  output logic              up_cmd_o,
  output logic              dn_cmd_o
);
  logic qualifies;

  // single-byte power command needs guard bit clear
  assign qualifies = valid_i && !(single_i && instr_i[GUARD_BIT]);
  assign up_cmd_o  = qualifies && !instr_i[P_BIT];
  assign dn_cmd_o  = qualifies &&  instr_i[P_BIT];

  always_comb begin
    a_excl_r2: assert (!(up_cmd_o && dn_cmd_o));
    a_guard_r3: assert (!(single_i && instr_i[GUARD_BIT]) || !(up_cmd_o || dn_cmd_o));
  end
endmodule

// File: rtl/mclk_monitor.sv
module mclk_monitor #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOSS_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_i,
  output logic absent_o
);
  localparam int unsigned CNT_W = $clog2(LOSS_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOSS_CYCLES);

  logic [SYNC_STAGES:0] sync_q;
  logic [CNT_W-1:0]     idle_cnt_q;
  logic                 edge_seen;

  generate
    for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= mclk_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               idle_cnt_q <= '0;
    else if (edge_seen)        idle_cnt_q <= '0;
    else if (idle_cnt_q != LIMIT) idle_cnt_q <= idle_cnt_q + 1'b1;
  end

  assign absent_o = (idle_cnt_q == LIMIT);

  p_edge_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |=> !absent_o);
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cnt_q <= LIMIT);
endmodule

// File: rtl/fs_gate.sv
module fs_gate #(
  parameter int unsigned FS_WAIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_up_i,
  input  logic fs_i,
  output logic open_o
);
  localparam int unsigned CNT_W = $clog2(FS_WAIT + 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(FS_WAIT);

  logic             fs_q;
  logic [CNT_W-1:0] fs_cnt_q;
  logic             fs_rise;

  assign fs_rise = fs_i && !fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q     <= 1'b0;
      fs_cnt_q <= '0;
    end else begin
      fs_q <= fs_i;
      if (!pwr_up_i)                        fs_cnt_q <= '0;
      else if (fs_rise && fs_cnt_q != DONE) fs_cnt_q <= fs_cnt_q + 1'b1;
    end
  end

  assign open_o = pwr_up_i && (fs_cnt_q == DONE);

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_cnt_q <= DONE);
  p_down_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |=> fs_cnt_q == '0);
  p_hold_no_fs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_up_i && !fs_rise) |=> $stable(fs_cnt_q));
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import codec_pwr_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned P_BIT       = 2,
  parameter int unsigned GUARD_BIT   = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOSS_CYCLES = 64,
  parameter int unsigned FS_WAIT     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclk_i,
  input  logic              fs_i,
  input  logic              bslot_i,
  input  logic [BYTE_W-1:0] instr_i,
  input  logic              instr_valid_i,
  input  logic              single_byte_i,
  output logic              pwr_up_o,
  output logic              tx_oe_o,
  output logic              aux_oe_o,
  output logic              clk_loss_o
);
  pwr_state_e state_q, state_d;
  logic up_cmd, dn_cmd, mclk_absent, gate_open;

  instr_decode #(.BYTE_W(BYTE_W), .P_BIT(P_BIT), .GUARD_BIT(GUARD_BIT)) u_dec (
    .instr_i (instr_i),
    .valid_i (instr_valid_i),
    .single_i(single_byte_i),
    .up_cmd_o(up_cmd),
    .dn_cmd_o(dn_cmd)
  );

  mclk_monitor #(.SYNC_STAGES(SYNC_STAGES), .LOSS_CYCLES(LOSS_CYCLES)) u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mclk_i  (mclk_i),
    .absent_o(mclk_absent)
  );

  always_comb begin
    state_d = state_q;
    if (mclk_absent) state_d = ST_LOSS;  // loss overrides any command
    else begin
      unique case (state_q)
        ST_DOWN: if (up_cmd) state_d = ST_UP;
        ST_UP:   if (dn_cmd) state_d = ST_DOWN;
        ST_LOSS: if (up_cmd) state_d = ST_UP;
        default: state_d = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_DOWN;
    else         state_q <= state_d;

  assign pwr_up_o   = (state_q == ST_UP);
  assign clk_loss_o = (state_q == ST_LOSS);

  fs_gate #(.FS_WAIT(FS_WAIT)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwr_up_i(pwr_up_o),
    .fs_i    (fs_i),
    .open_o  (gate_open)
  );

  assign tx_oe_o  = gate_open && bslot_i;
  assign aux_oe_o = pwr_up_o;

  p_loss_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_loss_o |-> (!tx_oe_o && !aux_oe_o && !pwr_up_o));
  p_absent_loss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_absent |=> clk_loss_o);
  p_loss_needs_up_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_loss_o && !up_cmd) |=> !pwr_up_o);
  p_down_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_up_o && dn_cmd) |=> !pwr_up_o);
  p_up_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_up_o) |-> !tx_oe_o);
  p_tx_needs_pwr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_o |-> (pwr_up_o && bslot_i));
endmodule

// File: tb/codec_pwr_ctrl_tb_top.sv
module codec_pwr_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, mclk = 1'b0, mclk_run = 1'b1;
  logic fs = 1'b0, bslot = 1'b0, valid = 1'b0, single = 1'b0;
  logic [7:0] instr = 8'h00;
  logic pwr_up, tx_oe, aux_oe, clk_loss;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  initial forever begin
    #37;
    if (mclk_run) mclk = ~mclk;
  end

  codec_pwr_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mclk_i(mclk), .fs_i(fs), .bslot_i(bslot),
    .instr_i(instr), .instr_valid_i(valid), .single_byte_i(single),
    .pwr_up_o(pwr_up), .tx_oe_o(tx_oe), .aux_oe_o(aux_oe), .clk_loss_o(clk_loss)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pwr,tx,aux,loss} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {pwr_up, tx_oe, aux_oe, clk_loss};
  endfunction

  task automatic send(input logic [7:0] b, input logic sb, input logic v);
    @(negedge clk); instr = b; single = sb; valid = v;
    @(negedge clk); valid = 1'b0; instr = 8'h00; single = 1'b0;
  endtask

  task automatic fs_pulse();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset", outs(), 4'b0000);
  endtask

  task automatic t_cmds();
    send(8'h04, 1'b0, 1'b0);           // R10 no strobe
    chk("R10 no strobe", outs(), 4'b0000);
    send(8'h02, 1'b1, 1'b1);           // R3 single, bit1=1, P=0
    chk("R3 guarded single ignored", outs(), 4'b0000);
    send(8'h00, 1'b1, 1'b1);           // R2 up
    chk("R2 up / R6 aux", outs(), 4'b1010);
    send(8'h06, 1'b1, 1'b1);           // R3 guarded down ignored
    chk("R3 guarded down ignored", outs(), 4'b1010);
    send(8'h06, 1'b0, 1'b1);           // R3 multi-byte acts
    chk("R3 multi-byte down", outs(), 4'b0000);
  endtask

  task automatic t_fs_wait();
    bslot = 1'b1;
    fs_pulse(); fs_pulse();            // R11 while down
    send(8'h00, 1'b0, 1'b1);
    chk("R11 down fs not counted", outs(), 4'b1010);
    fs_pulse();
    chk("R4 after first fs", outs(), 4'b1010);
    fs_pulse();
    chk("R4 after second fs", outs(), 4'b1110);
    bslot = 1'b0; #1;
    chk("R5 bslot low", outs(), 4'b1010);
    bslot = 1'b1; #1;
    chk("R5 bslot high", outs(), 4'b1110);
    send(8'h04, 1'b0, 1'b1);
    chk("R9 down", outs(), 4'b0000);
    send(8'h00, 1'b1, 1'b1);
    chk("R9 re-up gated", outs(), 4'b1010);
    fs_pulse();
    chk("R9 one fs", outs(), 4'b1010);
    fs_pulse();
    chk("R9 two fs", outs(), 4'b1110);
  endtask

  task automatic t_loss();
    mclk_run = 1'b0;
    wait_cyc(40);
    chk("R7 before limit", outs(), 4'b1110);
    wait_cyc(40);
    chk("R7 loss state", outs(), 4'b0001);
    send(8'h00, 1'b1, 1'b1);
    chk("R8 up ignored while absent", outs(), 4'b0001);
    mclk_run = 1'b1;
    wait_cyc(20);
    chk("R8 still loss until cmd", outs(), 4'b0001);
    send(8'h00, 1'b1, 1'b1);
    chk("R8 up clears loss, R4 gated", outs(), 4'b1010);
    fs_pulse(); fs_pulse();
    chk("R4 open after loss recovery", outs(), 4'b1110);
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_cmds();
    t_fs_wait();
    t_loss();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule